// File: doc/BRIEF.md
# Context-Based Access Protection Unit

This unit sits between two bus initiators, a primary system and a fallback system, and one downstream port. That port leads to a set of shared peripheral slots and a state-transfer buffer. One of two contexts is active at all times. Only the initiator that owns the active context can reach anything downstream. Within that context, each access is checked against a two-bit read/write permission held for the peripheral slot it addresses. The unit answers every request with either a grant or an error, and only granted accesses go on to the downstream port.

Permissions are stored per context for the first `NUM_CS` slots, which are the context-sensitive apertures. The remaining slots are static: they hold a single value that does not depend on the context. A context switch copies the target context's profile into the live table, one context-sensitive aperture per cycle. No request is answered while this copy runs, and the active context flips only when the copy is complete. The switch time therefore grows with `NUM_CS`, not with the total number of slots. For each initiator, a saturating counter and a sticky flag record how many accesses were refused.

Top module: `ctx_access_guard`

## Requirements
- R1: After reset the active context is primary (`active_ctx`=0), `upd_busy`, `upd_done`, all grants, errors, `slv_req`, both violation counters and both violation flags are 0.
- R2: A request from the initiator that does not own the active context (primary owns context 0, fallback owns context 1) is answered with an error one cycle later.
- R3: The slot index is address bits [AW-1:ASH]. For an active-initiator request to slot k < NUM_SLV, the unit gives a grant one cycle later if the live permission of slot k allows the access, and an error otherwise. Permission bit 0 allows reads (we=0) and bit 1 allows writes (we=1).
- R4: Slot NUM_SLV is the state-transfer buffer. The active initiator is always granted access to it, for both reads and writes.
- R5: An address whose slot index is above NUM_SLV matches no aperture and is answered with an error.
- R6: A granted access drives `slv_req`, `slv_we`, `slv_addr` and a one-hot `slv_sel` (bit k for slot k) in the same cycle as the grant. A refused access never drives `slv_req`.
- R7: A `sw_req` pulse accepted while idle holds `upd_busy` high for exactly NUM_CS cycles. In the cycle where `upd_busy` falls, `active_ctx` toggles and `upd_done` is high for one cycle.
- R8: During a switch, each live entry below NUM_CS takes the target context's profile value. The static entries (NUM_CS to NUM_SLV-1) keep their values.
- R9: No grant or error is produced while `upd_busy` is high. A request held through a switch is answered in the cycle after `upd_busy` falls, under the new context.
- R10: Each refused access increments that initiator's violation counter, which saturates at all-ones, and sets its sticky flag (bit 0 primary, bit 1 fallback). The flag stays set until reset.
- R11: A `sw_req` that arrives while `upd_busy` is high is ignored, so the context toggles only once.
- R12: A configuration write to an index below NUM_CS stores a profile entry for `cfg_ctx`. It also updates the live entry when `cfg_ctx` is the active context and no switch is running. A write to an index from NUM_CS to NUM_SLV-1 updates the static live entry directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_req | input | 1 | Primary initiator request |
| pri_we | input | 1 | Primary write (1) or read (0) |
| pri_addr | input | AW | Primary address |
| pri_gnt | output | 1 | Primary access granted |
| pri_err | output | 1 | Primary access refused |
| fbk_req | input | 1 | Fallback initiator request |
| fbk_we | input | 1 | Fallback write (1) or read (0) |
| fbk_addr | input | AW | Fallback address |
| fbk_gnt | output | 1 | Fallback access granted |
| fbk_err | output | 1 | Fallback access refused |
| cfg_we | input | 1 | Permission write strobe |
| cfg_ctx | input | 1 | Context of the profile entry written |
| cfg_idx | input | IDXW | Aperture index written |
| cfg_perm | input | 2 | Permission value {write, read} |
| sw_req | input | 1 | Request to switch to the other context |
| active_ctx | output | 1 | Active context, 0 primary, 1 fallback |
| upd_busy | output | 1 | Aperture rewrite in progress |
| upd_done | output | 1 | One-cycle pulse at the end of a rewrite |
| slv_req | output | 1 | Downstream access strobe |
| slv_we | output | 1 | Downstream write flag |
| slv_addr | output | AW | Downstream address |
| slv_sel | output | NUM_SLV+1 | One-hot downstream slot select |
| pri_viol_cnt | output | CNT_W | Primary refused-access count |
| fbk_viol_cnt | output | CNT_W | Fallback refused-access count |
| viol_flag | output | 2 | Sticky refusal flags per initiator |

## Verification
A request sampled at a clock edge gets its answer right after that edge. The grant or error, the downstream strobe, select and address, and the counter step all appear there. The bench drives each request on a falling edge and reads the answer on the next falling edge, which is exactly one register stage later. For a switch, the bench counts the falling edges on which `upd_busy` is high and expects exactly NUM_CS of them. It then looks for `upd_done` and the new context on the first falling edge after busy drops. A request held through the switch must be silent on every busy edge and on that first idle edge, and must be answered on the edge after it.

// File: rtl/ctxg_pkg.sv
package ctxg_pkg;
  localparam logic CTX_PRI = 1'b0;
  localparam logic CTX_FBK = 1'b1;

  // permission word: bit 0 read allowed, bit 1 write allowed
  typedef logic [1:0] perm_t;

  function automatic logic perm_allows(input perm_t p, input logic we);
    return we ? p[1] : p[0];
  endfunction
endpackage

// File: rtl/ctxg_perm_table.sv
module ctxg_perm_table
  import ctxg_pkg::*;
#(
  parameter int NUM_SLV = 6,
  parameter int NUM_CS  = 2,
  parameter int IDXW    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_ctx,
  input  logic [IDXW-1:0]          cfg_idx,
  input  perm_t                    cfg_perm,
  input  logic                     sw_req,
  output perm_t [NUM_SLV-1:0]      live_perm,
  output logic                     active_ctx,
  output logic                     upd_busy,
  output logic                     upd_done
);
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  perm_t [1:0][NUM_CS-1:0] prof;
  logic  [CSW-1:0]         step;
  logic                    tgt_ctx;
  logic                    cfg_is_cs, cfg_is_static, step_last;

  assign cfg_is_cs     = cfg_idx < IDXW'(NUM_CS);
  assign cfg_is_static = !cfg_is_cs && (cfg_idx < IDXW'(NUM_SLV));
  assign step_last     = step == CSW'(NUM_CS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prof       <= '0;
      live_perm  <= '0;
      step       <= '0;
      tgt_ctx    <= CTX_PRI;
      active_ctx <= CTX_PRI;
      upd_busy   <= 1'b0;
      upd_done   <= 1'b0;
    end else begin
      upd_done <= 1'b0;
      if (cfg_we) begin
        if (cfg_is_cs) begin
          prof[cfg_ctx][cfg_idx[CSW-1:0]] <= cfg_perm;
          if (cfg_ctx == active_ctx && !upd_busy) live_perm[cfg_idx] <= cfg_perm;
        end else if (cfg_is_static) begin
          live_perm[cfg_idx] <= cfg_perm;
        end
      end
      if (upd_busy) begin
        live_perm[step] <= prof[tgt_ctx][step];
        if (step_last) begin
          upd_busy   <= 1'b0;
          upd_done   <= 1'b1;
          active_ctx <= tgt_ctx;
        end else begin
          step <= step + CSW'(1);
        end
      end else if (sw_req) begin
        upd_busy <= 1'b1;
        step     <= '0;
        tgt_ctx  <= !active_ctx;
      end
    end
  end

  // run-length counter for the rewrite window
  logic [CSW:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else if (upd_busy) run_len <= run_len + (CSW+1)'(1);
    else run_len <= '0;
  end

  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    upd_busy |-> run_len < (CSW+1)'(NUM_CS));
  a_r7_done_flip: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> active_ctx != $past(active_ctx));
  a_r8_static_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_busy && !cfg_we) |=> $stable(live_perm[NUM_SLV-1:NUM_CS]));
  a_r11_ctx_steady: assert property (@(posedge clk) disable iff (!rst_n)
    upd_busy |=> $stable(tgt_ctx));
endmodule

// File: rtl/ctxg_req_check.sv
module ctxg_req_check
  import ctxg_pkg::*;
#(
  parameter int   NUM_SLV = 6,
  parameter int   SLOTW   = 4,
  parameter logic INIT_ID = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 we,
  input  logic [SLOTW-1:0]     slot,
  input  logic                 active_ctx,
  input  logic                 busy,
  input  perm_t [NUM_SLV-1:0]  live_perm,
  output logic                 ok_evt,
  output logic                 err_evt,
  output logic                 gnt,
  output logic                 err,
  output logic [NUM_SLV:0]     fwd_sel
);
  localparam int IW = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1;

  logic  hit_slv, hit_buf, owner, allow, eval;
  perm_t slot_perm;

  assign hit_slv   = slot < SLOTW'(NUM_SLV);
  assign hit_buf   = slot == SLOTW'(NUM_SLV);
  assign owner     = active_ctx == INIT_ID;
  assign slot_perm = hit_slv ? live_perm[slot[IW-1:0]] : '0;
  assign allow     = owner && (hit_buf || (hit_slv && perm_allows(slot_perm, we)));
  assign eval      = req && !busy;
  assign ok_evt    = eval && allow;
  assign err_evt   = eval && !allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt     <= 1'b0;
      err     <= 1'b0;
      fwd_sel <= '0;
    end else begin
      gnt     <= ok_evt;
      err     <= err_evt;
      fwd_sel <= ok_evt ? ((NUM_SLV+1)'(1) << slot) : '0;
    end
  end

  a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n) !(gnt && err));
  a_r2_owner: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> $past(active_ctx) == INIT_ID);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (!gnt && !err));
  a_r6_sel_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    gnt == (fwd_sel != '0));
endmodule

// File: rtl/ctxg_viol_log.sv
module ctxg_viol_log #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_evt,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (err_evt) begin
      flag <= 1'b1;
      if (!(&cnt)) cnt <= cnt + CNT_W'(1);
    end
  end

  a_r10_mono: assert property (@(posedge clk) disable iff (!rst_n) cnt >= $past(cnt));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n) $past(flag) |-> flag);
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n) $past(err_evt) |-> flag);
endmodule

// File: rtl/ctx_access_guard.sv
module ctx_access_guard
  import ctxg_pkg::*;
#(
  parameter int AW      = 16,
  parameter int ASH     = 12,
  parameter int NUM_SLV = 6,
  parameter int NUM_CS  = 2,
  parameter int CNT_W   = 8,
  parameter int IDXW    = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pri_req,
  input  logic               pri_we,
  input  logic [AW-1:0]      pri_addr,
  output logic               pri_gnt,
  output logic               pri_err,
  input  logic               fbk_req,
  input  logic               fbk_we,
  input  logic [AW-1:0]      fbk_addr,
  output logic               fbk_gnt,
  output logic               fbk_err,
  input  logic               cfg_we,
  input  logic               cfg_ctx,
  input  logic [IDXW-1:0]    cfg_idx,
  input  logic [1:0]         cfg_perm,
  input  logic               sw_req,
  output logic               active_ctx,
  output logic               upd_busy,
  output logic               upd_done,
  output logic               slv_req,
  output logic               slv_we,
  output logic [AW-1:0]      slv_addr,
  output logic [NUM_SLV:0]   slv_sel,
  output logic [CNT_W-1:0]   pri_viol_cnt,
  output logic [CNT_W-1:0]   fbk_viol_cnt,
  output logic [1:0]         viol_flag
);
  localparam int SLOTW = AW - ASH;

  perm_t [NUM_SLV-1:0]     live_perm;
  logic [1:0]              req_v, we_v, ok_v, errev_v, gnt_v, err_v;
  logic [1:0][AW-1:0]      addr_v;
  logic [1:0][NUM_SLV:0]   sel_v;
  logic [1:0][CNT_W-1:0]   cnt_v;

  assign req_v  = {fbk_req, pri_req};
  assign we_v   = {fbk_we, pri_we};
  assign addr_v = {fbk_addr, pri_addr};

  ctxg_perm_table #(.NUM_SLV(NUM_SLV), .NUM_CS(NUM_CS), .IDXW(IDXW)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_idx(cfg_idx),
    .cfg_perm(cfg_perm), .sw_req(sw_req), .live_perm(live_perm),
    .active_ctx(active_ctx), .upd_busy(upd_busy), .upd_done(upd_done)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_init
    ctxg_req_check #(.NUM_SLV(NUM_SLV), .SLOTW(SLOTW), .INIT_ID(gi[0])) u_chk (
      .clk(clk), .rst_n(rst_n), .req(req_v[gi]), .we(we_v[gi]),
      .slot(addr_v[gi][AW-1:ASH]), .active_ctx(active_ctx), .busy(upd_busy),
      .live_perm(live_perm), .ok_evt(ok_v[gi]), .err_evt(errev_v[gi]),
      .gnt(gnt_v[gi]), .err(err_v[gi]), .fwd_sel(sel_v[gi])
    );
    ctxg_viol_log #(.CNT_W(CNT_W)) u_log (
      .clk(clk), .rst_n(rst_n), .err_evt(errev_v[gi]),
      .cnt(cnt_v[gi]), .flag(viol_flag[gi])
    );
  end

  assign pri_gnt      = gnt_v[0];
  assign pri_err      = err_v[0];
  assign fbk_gnt      = gnt_v[1];
  assign fbk_err      = err_v[1];
  assign pri_viol_cnt = cnt_v[0];
  assign fbk_viol_cnt = cnt_v[1];
  assign slv_req      = |gnt_v;
  assign slv_sel      = sel_v[0] | sel_v[1];

  // at most one initiator owns the context, so at most one ok event per cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slv_we   <= 1'b0;
      slv_addr <= '0;
    end else if (ok_v[0]) begin
      slv_we   <= we_v[0];
      slv_addr <= addr_v[0];
    end else if (ok_v[1]) begin
      slv_we   <= we_v[1];
      slv_addr <= addr_v[1];
    end
  end

  a_r6_single_src: assert property (@(posedge clk) disable iff (!rst_n)
    slv_req |-> ($onehot(slv_sel) && $countones(gnt_v) == 1));
  a_r6_no_fwd_err: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_req |-> slv_sel == '0);
  a_r2_one_owner: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ok_v));
endmodule

// File: tb/ctx_access_guard_bench.sv
module ctx_access_guard_bench;
  localparam int AW = 16, ASH = 12, NUM_SLV = 6, NUM_CS = 2, CNT_W = 8, IDXW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pri_req = 0, pri_we = 0, fbk_req = 0, fbk_we = 0;
  logic [AW-1:0] pri_addr = '0, fbk_addr = '0;
  logic pri_gnt, pri_err, fbk_gnt, fbk_err;
  logic cfg_we = 0, cfg_ctx = 0, sw_req = 0;
  logic [IDXW-1:0] cfg_idx = '0;
  logic [1:0] cfg_perm = '0;
  logic active_ctx, upd_busy, upd_done, slv_req, slv_we;
  logic [AW-1:0] slv_addr;
  logic [NUM_SLV:0] slv_sel;
  logic [CNT_W-1:0] pri_viol_cnt, fbk_viol_cnt;
  logic [1:0] viol_flag;

  always #10 clk = ~clk;

  ctx_access_guard #(.AW(AW), .ASH(ASH), .NUM_SLV(NUM_SLV), .NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_ctx_access_guard (
    .clk(clk), .rst_n(rst_n), .pri_req(pri_req), .pri_we(pri_we), .pri_addr(pri_addr),
    .pri_gnt(pri_gnt), .pri_err(pri_err), .fbk_req(fbk_req), .fbk_we(fbk_we),
    .fbk_addr(fbk_addr), .fbk_gnt(fbk_gnt), .fbk_err(fbk_err), .cfg_we(cfg_we),
    .cfg_ctx(cfg_ctx), .cfg_idx(cfg_idx), .cfg_perm(cfg_perm), .sw_req(sw_req),
    .active_ctx(active_ctx), .upd_busy(upd_busy), .upd_done(upd_done),
    .slv_req(slv_req), .slv_we(slv_we), .slv_addr(slv_addr), .slv_sel(slv_sel),
    .pri_viol_cnt(pri_viol_cnt), .fbk_viol_cnt(fbk_viol_cnt), .viol_flag(viol_flag)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int exp_cnt[2] = '{0, 0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // vector: {initiator, we, expect_grant, address}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 16'h00A4}, {1'b0, 1'b1, 1'b0, 16'h0010},
    {1'b0, 1'b1, 1'b1, 16'h1FFC}, {1'b0, 1'b0, 1'b1, 16'h2000},
    {1'b0, 1'b1, 1'b0, 16'h2004}, {1'b0, 1'b1, 1'b1, 16'h3300},
    {1'b0, 1'b0, 1'b0, 16'h4000}, {1'b0, 1'b1, 1'b1, 16'h5A5A},
    {1'b0, 1'b0, 1'b1, 16'h6008}, {1'b0, 1'b1, 1'b1, 16'h6FF0},
    {1'b0, 1'b0, 1'b0, 16'h7000}, {1'b0, 1'b0, 1'b0, 16'hF123},
    {1'b1, 1'b0, 1'b0, 16'h0000}, {1'b1, 1'b1, 1'b0, 16'h6000}
  };

  task automatic cfg(input logic c, input int idx, input logic [1:0] p);
    @(negedge clk);
    cfg_we = 1; cfg_ctx = c; cfg_idx = IDXW'(idx); cfg_perm = p;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input string tag, input logic ini, input logic we,
                        input logic [AW-1:0] a, input logic exp_g);
    logic [NUM_SLV:0] exp_sel;
    int slot;
    slot = int'(a[AW-1:ASH]);
    exp_sel = exp_g ? ((NUM_SLV+1)'(1) << slot) : '0;
    @(negedge clk);
    if (ini) begin fbk_req = 1; fbk_we = we; fbk_addr = a; end
    else begin pri_req = 1; pri_we = we; pri_addr = a; end
    @(negedge clk);
    pri_req = 0; fbk_req = 0;
    if (!exp_g) exp_cnt[ini]++;
    chk({tag, " gnt"}, ini ? fbk_gnt : pri_gnt, exp_g);
    chk({tag, " err"}, ini ? fbk_err : pri_err, !exp_g);
    chk({tag, " slv_req (R6)"}, slv_req, exp_g);
    chk({tag, " slv_sel (R6)"}, slv_sel, exp_sel);
    if (exp_g) begin
      chk({tag, " slv_addr (R6)"}, slv_addr, a);
      chk({tag, " slv_we (R6)"}, slv_we, we);
    end
  endtask

  // switch; optionally fire a second sw_req while busy (R11)
  task automatic do_switch(input string tag, input bit twice);
    logic prev;
    int n;
    prev = active_ctx;
    @(negedge clk); sw_req = 1;
    @(negedge clk); sw_req = twice;
    n = 0;
    while (upd_busy && n < 50) begin
      n++;
      @(negedge clk); sw_req = 0;
    end
    chk({tag, " busy length (R7)"}, n, NUM_CS);
    chk({tag, " done pulse (R7)"}, upd_done, 1);
    chk({tag, " ctx toggled (R7)"}, active_ctx, !prev);
    @(negedge clk);
    chk({tag, " done one cycle (R7)"}, upd_done, 0);
    repeat (3) @(negedge clk);
    chk({tag, " single toggle (R11)"}, {upd_busy, active_ctx}, {1'b0, !prev});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctx", active_ctx, 0);
    chk("R1 busy/done", {upd_busy, upd_done}, 0);
    chk("R1 responses", {pri_gnt, pri_err, fbk_gnt, fbk_err, slv_req}, 0);
    chk("R1 counters", {pri_viol_cnt, fbk_viol_cnt, viol_flag}, 0);

    // R12: profiles for ctx0 also go live (ctx0 active); ctx1 profile stored only
    cfg(0, 0, 2'b01); cfg(0, 1, 2'b11);
    cfg(1, 0, 2'b10); cfg(1, 1, 2'b00);
    cfg(0, 2, 2'b01); cfg(1, 3, 2'b11); cfg(0, 4, 2'b00); cfg(0, 5, 2'b10);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      access($sformatf("vec%0d R2/R3/R4/R5", i), VEC[i][18], VEC[i][17], VEC[i][15:0], VEC[i][16]);
    end
    chk("R10 pri count", pri_viol_cnt, exp_cnt[0]);
    chk("R10 fbk count", fbk_viol_cnt, exp_cnt[1]);
    chk("R10 flags", viol_flag, 2'b11);

    // switch to fallback, sw_req repeated while busy
    do_switch("to_fbk", 1);
    access("R8 cs slot0 read now refused", 1, 0, 16'h0000, 0);
    access("R8 cs slot0 write now allowed", 1, 1, 16'h0000, 1);
    access("R8 cs slot1 cleared", 1, 0, 16'h1000, 0);
    access("R8 static slot3 kept", 1, 0, 16'h3000, 1);
    access("R8 static slot5 kept", 1, 1, 16'h5000, 1);
    access("R4 buffer fbk", 1, 1, 16'h6100, 1);
    access("R2 primary now inactive", 0, 0, 16'h3000, 0);
    cfg(1, 1, 2'b11);
    access("R12 active write goes live", 1, 0, 16'h1000, 1);
    cfg(0, 0, 2'b00);
    access("R12 inactive profile write not live", 1, 1, 16'h0000, 1);

    // R9: primary request held through the switch back
    @(negedge clk); sw_req = 1;
    @(negedge clk); sw_req = 0; pri_req = 1; pri_we = 0; pri_addr = 16'h1040;
    for (int n = 0; n < 50 && upd_busy; n++) begin
      chk("R9 silent while busy", {pri_gnt, pri_err}, 0);
      @(negedge clk);
    end
    chk("R9 ctx back", active_ctx, 0);
    chk("R9 not yet answered", {pri_gnt, pri_err}, 0);
    @(negedge clk);
    pri_req = 0;
    chk("R9 held request granted", {pri_gnt, pri_err}, 2'b10);
    access("R8 new ctx0 profile applied", 0, 0, 16'h0000, 0);
    chk("R10 pri count after switch", pri_viol_cnt, exp_cnt[0]);
    chk("R10 fbk count after switch", fbk_viol_cnt, exp_cnt[1]);

    // R10 saturation
    @(negedge clk); fbk_req = 1; fbk_we = 0; fbk_addr = 16'h2000;
    repeat (300) @(negedge clk);
    fbk_req = 0;
    @(negedge clk);
    chk("R10 saturated", fbk_viol_cnt, (1 << CNT_W) - 1);
    chk("R10 flag held", viol_flag, 2'b11);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule